// File: doc/BRIEF.md
# Cascadable Dual 16-bit Timer/Counter

This block holds two 16-bit count channels, A and B, behind a small word-addressed register port. Each channel steps on a prescaled tick (timer mode) or on its own conditioned external input (counter mode). The conditioning can invert the pin, pass it through a two-flop synchroniser, and pick out rising, falling or both edges. A channel counts up or down. When it reaches its terminal value it raises an event and loads its reload value, then either keeps running or stops, as configured.

Setting the extend bit of channel A joins the two channels into one 32-bit counter. The pair is then driven only through channel A's registers. Every event sets a per-channel pending flag, and each flag drives an interrupt line when its enable is set. A module-off input freezes all counting and masks the interrupt lines. Register contents stay intact while it is asserted.

Top module: `cascade_timer_pair`

## Requirements
- R1: After reset, every configuration, enable, reload, count, interrupt-enable and pending bit is zero, and `irq_o` is 0.
- R2: Register word addresses are 0 config A, 1 config B, 2 run A, 3 run B, 4 reload A (32-bit), 5 reload B (16-bit), 6 count A, 7 count B, 8 interrupt enable, 9 pending clear, 10 pending status. Config bits are: 0 running (read-only), 1 count up, 2 counter mode, 3 one-shot, 4 extend (A only; reads 0 in B), 5 invert input, 7:6 edge select (00 none, 01 rising, 10 falling, 11 both), 8 synchronise, 9 gate timer by input level, 10 count edges.
- R3: Run register writes act as commands. Bit 0 starts the channel, and bit 1 stops it; when both are set, stop wins. Bit 2 together with start loads the reload value into the count. Start without bit 2 resumes from the held count.
- R4: A down-counting channel decrements once per step. A step taken at zero raises an event and loads the reload value.
- R5: An up-counting channel increments once per step. A step taken at all-ones raises an event and loads the reload value.
- R6: With one-shot set, the running bit clears on the event and the count holds at the reload value. With one-shot clear, the channel keeps running.
- R7: With extend set, A and B form one 32-bit counter whose low half is A. Count A reads the full 32 bits, the terminal value is 32-bit zero or all-ones, the 32-bit reload A is used, the event lands on A's flag, and writes to B's config and run registers have no effect on the pair.
- R8: In timer mode a channel steps on every cycle with `tick_i` high. With bit 9 set, it steps only on such cycles in which its conditioned input is high.
- R9: In counter mode with bit 10 set, a channel steps only on the selected edges of its conditioned input, and edge select 00 never steps. With bit 10 clear, it steps on every cycle in which the conditioned input is high.
- R10: Inversion is applied to the pin first. With synchronise set, an input change reaches the count two cycles later than without.
- R11: Pending bit 0 belongs to A and bit 1 to B. An event sets its bit, and writing 1 to that bit of the clear register drops it. `irq_o` is pending AND enable.
- R12: While `mod_off_i` is high no count changes, register writes still take effect, the running bits are kept, and `irq_o` is 0. Counting resumes when it falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| mod_off_i | input | 1 | Freezes counting and masks interrupts |
| tick_i | input | 1 | Prescaled timer tick enable |
| ext_i | input | 2 | External count inputs, bit 0 for A, bit 1 for B |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | AW (4) | Register word address |
| reg_wdata_i | input | DW (32) | Register write data |
| reg_rdata_o | output | DW (32) | Register read data, combinational from address |
| irq_o | output | 2 | Per-channel interrupt lines |

## Verification
A wrong count shows up on the next read of the count register. A lost or spurious terminal detection shows up one step later, as a missing or early reload value and pending bit. A carry fault in the chained pair is exposed by a single step across the 16-bit boundary. An edge-detector or synchroniser fault appears as a wrong pulse total, or as a step landing one or two cycles off its expected cycle. Random reload values and step counts for both directions are compared against a reference model in the bench.

// File: rtl/ctp_pkg.sv
`timescale 1ns/1ps
package ctp_pkg;
   // configuration bit positions (software decodes these)
   localparam int CFG_MSB  = 10;
   localparam int B_RUN    = 0;
   localparam int B_UP     = 1;
   localparam int B_CNT    = 2;
   localparam int B_ONCE   = 3;
   localparam int B_EXT    = 4;
   localparam int B_INV    = 5;
   localparam int B_SEL_LO = 6;
   localparam int B_SYNC   = 8;
   localparam int B_GATE   = 9;
   localparam int B_EDGE   = 10;

   // register word addresses
   localparam int ADR_CFG_A  = 0;
   localparam int ADR_CFG_B  = 1;
   localparam int ADR_RUN_A  = 2;
   localparam int ADR_RUN_B  = 3;
   localparam int ADR_REL_A  = 4;
   localparam int ADR_REL_B  = 5;
   localparam int ADR_CNT_A  = 6;
   localparam int ADR_CNT_B  = 7;
   localparam int ADR_IEN    = 8;
   localparam int ADR_ICLR   = 9;
   localparam int ADR_IPEND  = 10;

   typedef enum logic [1:0] {
      EDGE_NONE = 2'b00,
      EDGE_RISE = 2'b01,
      EDGE_FALL = 2'b10,
      EDGE_BOTH = 2'b11
   } edge_sel_e;

   function automatic logic edge_pick(input logic [1:0] sel, input logic cur, input logic prev);
      case (edge_sel_e'(sel))
         EDGE_RISE: return cur & ~prev;
         EDGE_FALL: return ~cur & prev;
         EDGE_BOTH: return cur ^ prev;
         default:   return 1'b0;
      endcase
   endfunction
endpackage

// File: rtl/ctp_input_cond.sv
`timescale 1ns/1ps
module ctp_input_cond import ctp_pkg::*; #(
   parameter int SYNC_LEN = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pin_i,
   input  logic       inv_i,
   input  logic       sync_i,
   input  logic [1:0] sel_i,
   output logic       level_o,
   output logic       edge_o
);
   if (SYNC_LEN < 2) begin : g_bad_sync
      $error("SYNC_LEN must be at least 2");
   end

   logic                raw;
   logic [SYNC_LEN-1:0] sh_q;
   logic                prev_q;

   assign raw = pin_i ^ inv_i;

   for (genvar s = 0; s < SYNC_LEN; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     sh_q[s] <= 1'b0;
         else if (s == 0) sh_q[s] <= raw;
         else            sh_q[s] <= sh_q[(s == 0) ? 0 : s-1];
      end
   end

   assign level_o = sync_i ? sh_q[SYNC_LEN-1] : raw;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= level_o;
   end

   assign edge_o = edge_pick(sel_i, level_o, prev_q);
endmodule

// File: rtl/ctp_step_src.sv
`timescale 1ns/1ps
module ctp_step_src (
   input  logic cnt_mode_i,
   input  logic gate_i,
   input  logic edge_src_i,
   input  logic tick_i,
   input  logic level_i,
   input  logic edge_i,
   output logic step_o
);
   always_comb begin
      if (!cnt_mode_i) step_o = gate_i ? (tick_i & level_i) : tick_i;
      else             step_o = edge_src_i ? edge_i : level_i;
   end
endmodule

// File: rtl/ctp_lane.sv
`timescale 1ns/1ps
module ctp_lane #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         adv_i,
   input  logic         ld_i,
   input  logic [W-1:0] ld_val_i,
   input  logic         up_i,
   output logic [W-1:0] cnt_o,
   output logic         at_end_o
);
   if (W < 2) begin : g_bad_w
      $error("lane width must be at least 2");
   end

   localparam logic [W-1:0] ALL1 = '1;
   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt_q <= '0;
      else if (ld_i)  cnt_q <= ld_val_i;
      else if (adv_i) cnt_q <= up_i ? cnt_q + 1'b1 : cnt_q - 1'b1;
   end

   assign cnt_o    = cnt_q;
   assign at_end_o = up_i ? (cnt_q == ALL1) : (cnt_q == '0);

   // R4: a plain down step lowers the count by one
   a_r4_step_down: assert property (@(posedge clk) disable iff (!rst_n)
      (adv_i && !ld_i && !up_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

   // R5: a plain up step raises the count by one
   a_r5_step_up: assert property (@(posedge clk) disable iff (!rst_n)
      (adv_i && !ld_i && up_i && cnt_q != ALL1) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/cascade_timer_pair.sv
`timescale 1ns/1ps
module cascade_timer_pair import ctp_pkg::*; #(
   parameter int CH_W     = 16,
   parameter int DW       = 32,
   parameter int AW       = 4,
   parameter int SYNC_LEN = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          mod_off_i,
   input  logic          tick_i,
   input  logic [1:0]    ext_i,
   input  logic          reg_we_i,
   input  logic [AW-1:0] reg_addr_i,
   input  logic [DW-1:0] reg_wdata_i,
   output logic [DW-1:0] reg_rdata_o,
   output logic [1:0]    irq_o
);
   localparam int NCH = 2;
   localparam int CW  = 2 * CH_W;
   localparam logic [CFG_MSB:1] B_WMASK = ~(CFG_MSB'(1) << (B_EXT - 1));

   if (CW > DW) begin : g_bad_dw
      $error("data width must hold the chained count");
   end
   if (AW < 4) begin : g_bad_aw
      $error("address width must reach eleven registers");
   end

   // register state
   logic [CFG_MSB:1] cfg_q [NCH];
   logic [NCH-1:0]   en_q;
   logic [DW-1:0]    rel_a_q;
   logic [CH_W-1:0]  rel_b_q;
   logic [NCH-1:0]   ien_q;
   logic [NCH-1:0]   pend_q;

   // per-channel datapath nets
   logic [NCH-1:0]  lvl, edg, src, step, ev, adv, ld, up, at_end;
   logic [NCH-1:0]  wr_cfg, wr_run, run_ld;
   logic [CH_W-1:0] cnt [NCH];
   logic [CH_W-1:0] ldv [NCH];
   logic            chain, term_a, wr_rel_a, wr_rel_b, wr_ien, wr_clr;

   assign chain = cfg_q[0][B_EXT];

   // write decode
   assign wr_cfg[0] = reg_we_i && (reg_addr_i == AW'(ADR_CFG_A));
   assign wr_cfg[1] = reg_we_i && (reg_addr_i == AW'(ADR_CFG_B));
   assign wr_run[0] = reg_we_i && (reg_addr_i == AW'(ADR_RUN_A));
   assign wr_run[1] = reg_we_i && (reg_addr_i == AW'(ADR_RUN_B)) && !chain;
   assign wr_rel_a  = reg_we_i && (reg_addr_i == AW'(ADR_REL_A));
   assign wr_rel_b  = reg_we_i && (reg_addr_i == AW'(ADR_REL_B));
   assign wr_ien    = reg_we_i && (reg_addr_i == AW'(ADR_IEN));
   assign wr_clr    = reg_we_i && (reg_addr_i == AW'(ADR_ICLR));

   for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
      assign run_ld[ch] = wr_run[ch] & reg_wdata_i[0] & reg_wdata_i[2] & ~reg_wdata_i[1];

      ctp_input_cond #(.SYNC_LEN(SYNC_LEN)) u_cond (
         .clk     (clk),
         .rst_n   (rst_n),
         .pin_i   (ext_i[ch]),
         .inv_i   (cfg_q[ch][B_INV]),
         .sync_i  (cfg_q[ch][B_SYNC]),
         .sel_i   (cfg_q[ch][B_SEL_LO+1:B_SEL_LO]),
         .level_o (lvl[ch]),
         .edge_o  (edg[ch])
      );

      ctp_step_src u_src (
         .cnt_mode_i (cfg_q[ch][B_CNT]),
         .gate_i     (cfg_q[ch][B_GATE]),
         .edge_src_i (cfg_q[ch][B_EDGE]),
         .tick_i     (tick_i),
         .level_i    (lvl[ch]),
         .edge_i     (edg[ch]),
         .step_o     (src[ch])
      );

      ctp_lane #(.W(CH_W)) u_lane (
         .clk      (clk),
         .rst_n    (rst_n),
         .adv_i    (adv[ch]),
         .ld_i     (ld[ch]),
         .ld_val_i (ldv[ch]),
         .up_i     (up[ch]),
         .cnt_o    (cnt[ch]),
         .at_end_o (at_end[ch])
      );
   end

   // step, event and chaining
   always_comb begin
      step[0] = en_q[0] & src[0] & ~mod_off_i;
      step[1] = ~chain & en_q[1] & src[1] & ~mod_off_i;
      up[0]   = cfg_q[0][B_UP];
      up[1]   = chain ? cfg_q[0][B_UP] : cfg_q[1][B_UP];
      term_a  = chain ? (at_end[0] & at_end[1]) : at_end[0];
      ev[0]   = step[0] & term_a;
      ev[1]   = step[1] & at_end[1];
      adv[0]  = step[0] & ~ev[0];
      ld[0]   = ev[0] | run_ld[0];
      adv[1]  = chain ? (adv[0] & at_end[0]) : (step[1] & ~ev[1]);
      ld[1]   = chain ? ld[0] : (ev[1] | run_ld[1]);
      ldv[0]  = rel_a_q[CH_W-1:0];
      ldv[1]  = chain ? rel_a_q[CW-1:CH_W] : rel_b_q;
   end

   // register file
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int ch = 0; ch < NCH; ch++) cfg_q[ch] <= '0;
         en_q    <= '0;
         rel_a_q <= '0;
         rel_b_q <= '0;
         ien_q   <= '0;
         pend_q  <= '0;
      end else begin
         for (int ch = 0; ch < NCH; ch++) begin
            if (wr_cfg[ch])
               cfg_q[ch] <= reg_wdata_i[CFG_MSB:1] & ((ch == 0) ? {CFG_MSB{1'b1}} : B_WMASK);
            if (wr_run[ch] && (reg_wdata_i[0] || reg_wdata_i[1]))
               en_q[ch] <= ~reg_wdata_i[1];
            else if (ev[ch] && cfg_q[ch][B_ONCE])
               en_q[ch] <= 1'b0;
         end
         if (wr_rel_a) rel_a_q <= reg_wdata_i;
         if (wr_rel_b) rel_b_q <= reg_wdata_i[CH_W-1:0];
         if (wr_ien)   ien_q   <= reg_wdata_i[NCH-1:0];
         pend_q <= (pend_q & ~(wr_clr ? reg_wdata_i[NCH-1:0] : '0)) | ev;
      end
   end

   // read mux
   always_comb begin
      reg_rdata_o = '0;
      case (reg_addr_i)
         AW'(ADR_CFG_A): reg_rdata_o = DW'({cfg_q[0], en_q[0]});
         AW'(ADR_CFG_B): reg_rdata_o = DW'({cfg_q[1], en_q[1]});
         AW'(ADR_REL_A): reg_rdata_o = rel_a_q;
         AW'(ADR_REL_B): reg_rdata_o = DW'(rel_b_q);
         AW'(ADR_CNT_A): reg_rdata_o = chain ? DW'({cnt[1], cnt[0]}) : DW'(cnt[0]);
         AW'(ADR_CNT_B): reg_rdata_o = DW'(cnt[1]);
         AW'(ADR_IEN):   reg_rdata_o = DW'(ien_q);
         AW'(ADR_IPEND): reg_rdata_o = DW'(pend_q);
         default:        reg_rdata_o = '0;
      endcase
   end

   assign irq_o = pend_q & ien_q & {NCH{~mod_off_i}};

   // R3: a stop command always leaves channel A halted
   a_r3_stop_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_run[0] && reg_wdata_i[1]) |=> !en_q[0]);

   // R6: a one-shot event halts the channel unless a command overrides it
   a_r6_once_halts: assert property (@(posedge clk) disable iff (!rst_n)
      (ev[0] && cfg_q[0][B_ONCE] && !wr_run[0]) |=> !en_q[0]);

   // R11: a clear with no simultaneous event drops the pending flag
   a_r11_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_clr && reg_wdata_i[0] && !ev[0]) |=> !pend_q[0]);

   // R12: module-off freezes the counts
   a_r12_off_freezes: assert property (@(posedge clk) disable iff (!rst_n)
      (mod_off_i && !reg_we_i) |=> ($stable(cnt[0]) && $stable(cnt[1])));
endmodule

// File: tb/cascade_timer_pair_tb.sv
`timescale 1ns/1ps
module cascade_timer_pair_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mod_off_i = 1'b0;
   logic        tick_i = 1'b0;
   logic [1:0]  ext_i = 2'b00;
   logic        reg_we_i = 1'b0;
   logic [3:0]  reg_addr_i = '0;
   logic [31:0] reg_wdata_i = '0;
   logic [31:0] reg_rdata_o;
   logic [1:0]  irq_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   cascade_timer_pair u_dut (
      .clk(clk), .rst_n(rst_n), .mod_off_i(mod_off_i), .tick_i(tick_i),
      .ext_i(ext_i), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
      .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .irq_o(irq_o)
   );

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got %h exp %h", tag, got, exp);
      end
   endtask

   task automatic wr(input int a, input logic [31:0] d);
      reg_addr_i = a[3:0]; reg_wdata_i = d; reg_we_i = 1'b1;
      @(posedge clk); #1;
      reg_we_i = 1'b0;
   endtask

   task automatic rd(input int a, output logic [31:0] d);
      reg_addr_i = a[3:0];
      #1;
      d = reg_rdata_o;
   endtask

   task automatic cyc(input int n);
      for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
   endtask

   task automatic tk(input int n);
      for (int i = 0; i < n; i++) begin tick_i = 1'b1; @(posedge clk); #1; end
      tick_i = 1'b0;
   endtask

   // reference: n steps of a w-bit cyclic counter
   function automatic logic [31:0] mdl(input logic [31:0] c0, input logic [31:0] rel,
                                       input bit upc, input int w, input int n, output int evn);
      logic [31:0] c = c0;
      logic [31:0] m = (w >= 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 1);
      evn = 0;
      for (int i = 0; i < n; i++) begin
         if (upc ? (c == m) : (c == 0)) begin c = rel; evn++; end
         else c = upc ? ((c + 1) & m) : ((c - 1) & m);
      end
      return c;
   endfunction

   task automatic pulse_train(input int k, input int hold);
      for (int i = 0; i < k; i++) begin
         ext_i[0] = 1'b1; cyc(hold);
         ext_i[0] = 1'b0; cyc(hold);
      end
      ext_i[0] = 1'b1; cyc(hold);
   endtask

   initial begin
      logic [31:0] d;
      logic [31:0] exp;
      int evn, rel, n;
      void'($urandom(32'd4242));
      cyc(3);
      rst_n = 1'b1;
      cyc(1);

      // R1 reset state
      rd(0, d); chk("R1 cfg A", d, 0);
      rd(6, d); chk("R1 count A", d, 0);
      rd(4, d); chk("R1 reload A", d, 0);
      rd(10, d); chk("R1 pending", d, 0);
      chk("R1 irq", {30'd0, irq_o}, 0);

      // R2 layout: B has no extend bit, running bit is read-only
      wr(1, 32'h7FF); rd(1, d); chk("R2 cfg B mask", d, 32'h7EE);
      wr(0, 32'h001); rd(0, d); chk("R2 run bit read-only", d, 0);
      wr(1, 0);

      // R4 / R6 one-shot down count
      wr(0, 32'h008); wr(4, 5); wr(2, 32'h5);
      rd(6, d); chk("R3 start loads reload", d, 5);
      rd(0, d); chk("R3 running bit", d, 32'h009);
      tk(5); rd(6, d); chk("R4 reach zero", d, 0);
      rd(10, d); chk("R4 no event yet", d, 0);
      tk(1); rd(6, d); chk("R4 reload on zero", d, 5);
      rd(10, d); chk("R11 pending A", d, 1);
      rd(0, d); chk("R6 one-shot halted", d, 32'h008);
      tk(3); rd(6, d); chk("R6 held after one-shot", d, 5);
      chk("R11 irq masked", {30'd0, irq_o}, 0);
      wr(8, 1); chk("R11 irq on enable", {30'd0, irq_o}, 1);
      wr(9, 1); rd(10, d); chk("R11 clear", d, 0);
      wr(8, 0);

      // R4 random cyclic down counting
      for (int it = 0; it < 6; it++) begin
         rel = 3 + int'($urandom % 38); n = int'($urandom % 120);
         wr(0, 0); wr(4, rel); wr(9, 3); wr(2, 32'h5);
         tk(n);
         exp = mdl(rel, rel, 1'b0, 16, n, evn);
         rd(6, d); chk("R4 cyclic down count", d, exp);
         rd(10, d); chk("R6 cyclic event", d, (evn > 0) ? 1 : 0);
         rd(0, d); chk("R6 cyclic keeps running", d[0], 1);
         wr(2, 32'h2);
      end

      // R5 random cyclic up counting near the top
      for (int it = 0; it < 6; it++) begin
         rel = 32'hFFF0 + int'($urandom % 15); n = int'($urandom % 60);
         wr(0, 32'h002); wr(4, rel); wr(9, 3); wr(2, 32'h5);
         tk(n);
         exp = mdl(rel, rel, 1'b1, 16, n, evn);
         rd(6, d); chk("R5 cyclic up count", d, exp);
         rd(10, d); chk("R5 up event", d, (evn > 0) ? 1 : 0);
         wr(2, 32'h2);
      end

      // R3 stop, resume, start+stop
      wr(0, 0); wr(4, 50); wr(2, 32'h5); tk(5);
      rd(6, d); chk("R3 before stop", d, 45);
      wr(2, 32'h2); tk(3); rd(6, d); chk("R3 stopped holds", d, 45);
      wr(2, 32'h1); tk(2); rd(6, d); chk("R3 resume no reload", d, 43);
      wr(2, 32'h3); tk(2); rd(6, d); chk("R3 stop wins", d, 43);
      rd(0, d); chk("R3 stop wins run bit", d[0], 0);

      // R7 chained 32-bit
      wr(9, 3); wr(0, 32'h010); wr(4, 32'h0001_0002); wr(2, 32'h5);
      rd(6, d); chk("R7 32-bit load", d, 32'h0001_0002);
      tk(3); rd(6, d); chk("R7 borrow across 16-bit", d, 32'h0000_FFFF);
      rd(7, d); chk("R7 upper half", d, 0);
      wr(1, 32'h002); wr(3, 32'h2); tk(1);
      rd(6, d); chk("R7 B writes ignored", d, 32'h0000_FFFE);
      wr(2, 32'h2); wr(0, 32'h012); wr(4, 32'h0000_FFFE); wr(2, 32'h5);
      tk(2); rd(6, d); chk("R7 carry across 16-bit", d, 32'h0001_0000);
      wr(2, 32'h2); wr(9, 3); wr(4, 32'hFFFF_FFFE); wr(2, 32'h5);
      tk(1); rd(6, d); chk("R7 at 32-bit top", d, 32'hFFFF_FFFF);
      rd(10, d); chk("R7 no early event", d, 0);
      tk(1); rd(6, d); chk("R7 32-bit reload", d, 32'hFFFF_FFFE);
      rd(10, d); chk("R7 event on A flag", d, 1);
      wr(2, 32'h2); wr(0, 0); wr(1, 0); wr(9, 3);

      // R9 edge counting, up from zero: 3 pulses then left high
      for (int s = 0; s < 4; s++) begin
         ext_i[0] = 1'b0;
         wr(0, 32'h406 | (s << 6)); wr(4, 0); cyc(1); wr(2, 32'h5);
         pulse_train(3, 2);
         case (s)
            0: exp = 0;
            1: exp = 4;
            2: exp = 3;
            default: exp = 7;
         endcase
         rd(6, d); chk($sformatf("R9 edge select %0d", s), d, exp);
         wr(2, 32'h2); ext_i[0] = 1'b0; cyc(2);
      end

      // R10 inversion: rising of inverted pin counts pin falls
      wr(0, 32'h426 | (1 << 6)); wr(4, 0); cyc(1); wr(2, 32'h5);
      pulse_train(3, 2);
      rd(6, d); chk("R10 inverted rising", d, 3);
      wr(2, 32'h2); ext_i[0] = 1'b0; cyc(2);

      // R10 synchroniser latency
      wr(0, 32'h506 | (1 << 6)); wr(4, 0); cyc(3); wr(2, 32'h5);
      ext_i[0] = 1'b1; cyc(2);
      rd(6, d); chk("R10 sync not yet", d, 0);
      cyc(1); rd(6, d); chk("R10 sync after two", d, 1);
      ext_i[0] = 1'b0; cyc(3);
      pulse_train(2, 3); cyc(3);
      rd(6, d); chk("R10 sync total", d, 4);
      wr(2, 32'h2); ext_i[0] = 1'b0; cyc(3);

      // R9 level counting in counter mode
      wr(0, 32'h006); wr(4, 0); wr(2, 32'h5);
      ext_i[0] = 1'b1; cyc(5); ext_i[0] = 1'b0; cyc(2);
      rd(6, d); chk("R9 level count", d, 5);
      wr(2, 32'h2);

      // R8 gated timer
      wr(0, 32'h200); wr(4, 100); wr(2, 32'h5);
      for (int i = 0; i < 7; i++) begin
         ext_i[0] = (i < 4); tick_i = 1'b1; @(posedge clk); #1;
      end
      tick_i = 1'b0; ext_i[0] = 1'b0;
      rd(6, d); chk("R8 gated ticks", d, 96);
      wr(2, 32'h2);

      // R12 module off
      wr(9, 3); wr(0, 0); wr(4, 10); wr(8, 1); wr(2, 32'h5);
      tk(11); rd(6, d); chk("R12 pre count", d, 10);
      chk("R11 irq raised", {30'd0, irq_o}, 1);
      mod_off_i = 1'b1; #1;
      chk("R12 irq masked", {30'd0, irq_o}, 0);
      tk(4); rd(6, d); chk("R12 frozen", d, 10);
      wr(4, 20); rd(4, d); chk("R12 write accepted", d, 20);
      rd(0, d); chk("R12 run bit kept", d[0], 1);
      mod_off_i = 1'b0; #1;
      chk("R12 irq back", {30'd0, irq_o}, 1);
      tk(2); rd(6, d); chk("R12 resumes", d, 8);
      wr(2, 32'h2); wr(9, 3);

      // R11 channel B index
      wr(1, 32'h008); wr(5, 2); wr(8, 3); wr(3, 32'h5);
      tk(3);
      rd(10, d); chk("R11 pending B index", d, 2);
      chk("R11 irq B", {30'd0, irq_o}, 2);
      rd(7, d); chk("R6 B reload", d, 2);
      rd(1, d); chk("R6 B halted", d, 32'h008);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog got hung exp finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule